// File: doc/BRIEF.md
# MDIO management master

This block lets a host read and write registers in an external Ethernet PHY over the two-wire management bus. It drives the management clock and the bidirectional data line. The data line is split into an output value, an output enable and an input sample, so that the pad tri-state sits outside the block. The host writes one command word to start a transfer. It watches an idle flag to know when the bus is free. After a read, it finds the PHY's 16-bit reply in the low half of that same word.

The management clock comes from the system clock through a divisor chosen by a 3-bit code. Software must choose a code that keeps the management clock at or below 2.5 MHz. For example, code 3 (divide by 48) on a 111.11 MHz source gives about 2.31 MHz. Each transfer is a clause-22 frame of 64 clock periods. The block drives the whole frame for a write. For a read, it lets go of the line for the turnaround and data bits and samples the PHY's reply.

Top module: `mdio_master`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `rd_word` is 0.
- R2: The divisor code maps 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, 6→128, 7→224 system clocks per `mdc` period. Within a frame, `mdc` is high for exactly half the period and low for the other half.
- R3: A write of `wr_en` while `idle` is 1 starts a frame at that clock edge. From the next cycle on, `idle` is 0, `mdio_oe` is 1 and `mdio_o` is 1 (the first preamble bit).
- R4: The command word fields are: opcode at bits [29:28], PHY address at [27:23], register address at [22:18] and write data at [15:0]. Bits [31:30] and [17:16] are not sent. The frame, bit by bit in `mdc` periods, is 32 ones, then 0 and 1, then the two opcode bits, the PHY address MSB first, the register address MSB first, the turnaround, and 16 data bits MSB first. The opcode bits are sent as written; 10 is a read and 01 is a write. For any opcode other than 10, the block drives the turnaround as 1 then 0, and drives every bit of the frame.
- R5: While the line is driven, `mdio_o` changes only on the clock edge at which `mdc` falls. `mdio_oe` also changes only at such an edge, except when a frame starts.
- R6: For opcode 10, `mdio_oe` goes low from the first turnaround bit (frame bit 46, counting from 0) to the end of the frame. `mdio_i` is sampled when `mdc` rises during the 16 data bits. At completion, `rd_word` holds the command word with bits [15:0] replaced by the sampled data, MSB first.
- R7: `idle` stays 0 for exactly 64 × divisor clock cycles after the start edge. It returns to 1 on the edge where `mdc` falls after the last data bit.
- R8: A `wr_en` while `idle` is 0 is ignored. It does not change `rd_word`, the frame contents or the frame length. The divisor code is captured at the start edge, so changing `div_code` during a frame has no effect on that frame.
- R9: While `idle` is 1, `mdc` is held at 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the source of the management clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 32 | Command word: opcode, addresses, write data |
| div_code | input | 3 | Encoded management clock divisor select |
| rd_word | output | 32 | Command word readback; low 16 bits hold read data after a read |
| idle | output | 1 | 1 when no transfer is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (1 = drive) |
| mdio_i | input | 1 | Data line input value |

## Verification
The hardest case to reach is a host write, and a change of the divisor code, that lands in the middle of a transfer. Reaching it needs exact timing against a frame that can last thousands of cycles. The bench starts every transfer and then, at a fixed cycle while `idle` is 0, writes the inverted command word and flips all divisor bits. It then checks three things: the captured frame, the busy length and the readback all still match the original command. The bench also acts as a PHY that changes its reply bit right after each rising `mdc`. This means a read that samples on the wrong edge or at the wrong bit returns shifted data. The bench sweeps all eight divisor codes for both a write and a read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int DIV_CODE_W = 3;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  // System clocks per management clock period for each select code.
  function automatic int unsigned div_of_code(input logic [DIV_CODE_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 32;
      3'd3:    return 48;
      3'd4:    return 64;
      3'd5:    return 96;
      3'd6:    return 128;
      default: return 224;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  run,
  input  logic [DIV_CODE_W-1:0] div_code,
  output logic                  mdc,
  output logic                  rise_ev,
  output logic                  fall_ev
);

  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick    = run && (cnt_q == (half_q - 1'b1));
  assign rise_ev = tick && !mdc;
  assign fall_ev = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '0;
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      // divisor is captured here and held for the whole frame
      half_q <= CNT_W'(div_of_code(div_code) >> 1);
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt_q <= '0;
        mdc   <= ~mdc;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end
  end

  // R9: clock parked low outside a frame
  p_mdc_low_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc);

  // R2: half-period counter never passes its limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < half_q));

  // R2: every clock edge restarts the half-period count
  p_toggle_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (mdc != $past(mdc))) |-> (cnt_q == '0));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  localparam int WORD_W = 2 * ADDR_W + DATA_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] cmd,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int FRAME_W = PRE_LEN + WORD_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int REG_LSB = DATA_W + 2;
  localparam int PHY_LSB = REG_LSB + ADDR_W;
  localparam int OP_LSB  = PHY_LSB + ADDR_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(FRAME_W - DATA_W - 2);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_W - DATA_W);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sr_q;
  logic [IDX_W-1:0]   bidx_q;
  logic               rd_q;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, cmd[OP_LSB +: 2],
                  cmd[PHY_LSB +: ADDR_W], cmd[REG_LSB +: ADDR_W],
                  2'b10, cmd[DATA_W-1:0]};

  assign done = busy && fall_ev && (bidx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      sr_q    <= '0;
      bidx_q  <= '0;
      rd_q    <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      rd_q    <= (cmd[OP_LSB +: 2] == OP_READ);
      sr_q    <= frame;
      mdio_o  <= frame[FRAME_W-1];
      mdio_oe <= 1'b1;
      bidx_q  <= '0;
    end else if (busy) begin
      if (rise_ev && rd_q && (bidx_q >= DAT_IDX))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (fall_ev) begin
        if (bidx_q == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          bidx_q  <= '0;
        end else begin
          bidx_q  <= bidx_q + 1'b1;
          sr_q    <= sr_q << 1;
          mdio_o  <= sr_q[FRAME_W-2];
          mdio_oe <= !(rd_q && ((bidx_q + 1'b1) >= REL_IDX));
        end
      end
    end
  end

  // R6: line released from turnaround onward during a read
  p_release_read_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (bidx_q >= REL_IDX)) |-> !mdio_oe);

  // R9: line released outside a frame
  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R3: a start drives the first preamble one at once
  p_start_drives_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && mdio_oe && mdio_o));

  // R4: preamble bits are all ones
  p_preamble_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && (bidx_q < IDX_W'(PRE_LEN))) |-> mdio_o);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int CNT_W   = 8,
  localparam int WORD_W = 2 * ADDR_W + DATA_W + 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [DIV_CODE_W-1:0] div_code,
  output logic [WORD_W-1:0]     rd_word,
  output logic                  idle,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i
);

  localparam int OP_LSB = DATA_W + 2 + 2 * ADDR_W;

  logic              busy;
  logic              start;
  logic              rise_ev;
  logic              fall_ev;
  logic              done;
  logic [DATA_W-1:0] rx_data;

  assign start = wr_en && !busy;
  assign idle  = !busy;

  mdio_clkdiv #(
    .CNT_W(CNT_W)
  ) clkdiv_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (busy),
    .div_code(div_code),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_shifter #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) shifter_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cmd    (wr_data),
    .rise_ev(rise_ev),
    .fall_ev(fall_ev),
    .mdio_i (mdio_i),
    .busy   (busy),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .done   (done),
    .rx_data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
    end else if (start) begin
      rd_word <= wr_data;
    end else if (done && (rd_word[OP_LSB +: 2] == OP_READ)) begin
      rd_word[DATA_W-1:0] <= rx_data;
    end
  end

  // R8: command word held for the whole frame, host writes ignored
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(rd_word) || !busy));

  // R5: driven data only moves with a falling management clock
  p_mdio_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  // R7: frame ends only on a falling management clock
  p_end_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(mdc));

endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  div_code = '0;
  logic        mdio_i = 1'b1;
  logic [31:0] rd_word;
  logic        idle, mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .div_code(div_code), .rd_word(rd_word), .idle(idle), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int div_for(input int c);
    case (c)
      0: return 8;    1: return 16;   2: return 32;   3: return 48;
      4: return 64;   5: return 96;   6: return 128;  default: return 224;
    endcase
  endfunction

  task automatic run_op(input int code, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] reg_a,
                        input logic [15:0] wdata, input logic [15:0] pdata);
    logic [31:0] w;
    logic [63:0] exp_f, got_f, got_oe, mask, exp_oe;
    int busy_n, hi_n, rises, bad, dv;
    logic pm, po, poe;
    bit is_rd;
    dv = div_for(code);
    is_rd = (op == 2'b10);
    w = {2'b11, op, phy, reg_a, 2'b01, wdata};
    exp_f = {32'hFFFF_FFFF, 2'b01, op, phy, reg_a, 2'b10, wdata};
    @(negedge clk);
    wr_data = w; div_code = code[2:0]; wr_en = 1'b1; mdio_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(!idle && mdio_oe && mdio_o, "R3", "start drive {idle,oe,o}",
        {idle, mdio_oe, mdio_o}, 3'b011);
    busy_n = 0; hi_n = 0; rises = 0; bad = 0;
    got_f = '0; got_oe = '0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (!idle && busy_n < 20000) begin
      busy_n++;
      if (mdc) hi_n++;
      if (busy_n == 40) begin
        wr_en = 1'b1; wr_data = ~w; div_code = code[2:0] ^ 3'b111;
      end
      if (busy_n == 41) wr_en = 1'b0;
      @(negedge clk);
      if (!pm && mdc && rises < 64) begin
        got_f[63-rises]  = mdio_o;
        got_oe[63-rises] = mdio_oe;
        rises++;
      end
      if (((mdio_oe != poe) || (mdio_oe && (mdio_o != po))) && !(pm && !mdc)) bad++;
      mdio_i = (rises >= 48 && rises < 64) ? pdata[63-rises] : 1'b1;
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    mdio_i = 1'b1;
    chk(busy_n == 64 * dv, "R7/R8", "busy cycles", busy_n, 64 * dv);
    chk(hi_n == 32 * dv, "R2", "mdc high cycles", hi_n, 32 * dv);
    chk(rises == 64, "R2", "mdc rising edges", rises, 64);
    chk(bad == 0, "R5", "line changes off falling edge", bad, 0);
    mask   = is_rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    exp_oe = is_rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    chk((got_f & mask) == (exp_f & mask), "R4/R8", "frame bits",
        got_f & mask, exp_f & mask);
    chk(got_oe == exp_oe, is_rd ? "R6" : "R4", "drive enables", got_oe, exp_oe);
    if (is_rd)
      chk(rd_word == {w[31:16], pdata}, "R6", "read data word", rd_word, {w[31:16], pdata});
    else
      chk(rd_word == w, "R8", "write word readback", rd_word, w);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(idle && !mdc && !mdio_oe, "R9", "idle {idle,mdc,oe}",
          {idle, mdc, mdio_oe}, 3'b100);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe && rd_word == 0, "R1", "reset state",
        {idle, mdc, mdio_oe, rd_word}, {3'b100, 32'h0});
    for (int c = 0; c < 8; c++) begin
      run_op(c, 2'b01, 5'(c + 1), 5'(31 - c), 16'hA5C3 ^ 16'(c * 16'h1111), 16'h0);
      run_op(c, 2'b10, 5'(31 - c), 5'(c + 2), 16'h0, 16'h3C96 ^ 16'(c * 16'h0F01));
    end
    run_op(0, 2'b01, 5'h1F, 5'h00, 16'hFFFF, 16'h0);
    run_op(0, 2'b10, 5'h00, 5'h1F, 16'h0, 16'h8001);
    run_op(0, 2'b11, 5'h15, 5'h0A, 16'h0001, 16'hFFFF);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule